// File: doc/BRIEF.md
# External Peripheral Bus Access Sequencer

This block turns single requests from an internal bus into read and write cycles on an asynchronous parallel bus that serves two external peripheral banks. Each bank has its own active-low chip select and its own active-low wait input. All banks share one 22-bit address, one 16-bit data path, two active-low byte selects and two active-low strobes, one for reads and one for writes. The data path is brought out as a separate output, output enable and input, so the pad ring can build the tri-state bus.

A bank is either 16 bits or 8 bits wide. Four per-access timing values are counted in system clock cycles: address setup, read strobe width, write strobe width and data-off. They are sampled together with the request. The selected bank's wait input can stretch a strobe once its minimum width has elapsed. A 16-bit request to an 8-bit bank is carried out as two byte cycles. The requester sees a valid/ready request channel and a one-cycle completion pulse that carries the read data.

The request channel applies back-pressure: `req_ready` is high only while the sequencer is idle. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high. The requester must keep every request field and the timing inputs steady until that edge. The completion pulse cannot be stalled.

Top module: `xio_bus_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, both chip selects, both byte selects and both strobes are high, and `io_data_oe` is 0. During an access only the chip select of the requested bank is low: `io_cs_n` is 2'b10 for bank 0 and 2'b01 for bank 1.
- R2: With `cfg_setup` = S, chip select and address are low and valid for S+1 clock cycles before the strobe falls.
- R3: Without wait, `io_re_n` stays low for `cfg_rd_width`+1 cycles on a read and `io_we_n` stays low for `cfg_wr_width`+1 cycles on a write. Only the strobe that matches the direction is used. The two strobes are never low together. Address and byte selects stay steady while a strobe is low, and the first byte cycle drives the requested address.
- R4: With `cfg_data_off` = D, chip select and address stay asserted for D+1 cycles after the strobe rises. On a write, `io_data_oe` is 1 for every cycle in which a chip select is low. On a read it stays 0.
- R5: When the selected bank's wait input is low at the end of the minimum strobe width, the strobe is held. It rises on the third rising clock edge after wait goes high, because wait passes through a two-stage synchroniser. The read data is then taken on that edge.
- R6: Wait is not examined before the minimum strobe width has elapsed, so a wait pulse that ends early does not lengthen the strobe. The wait input of the bank that is not selected has no effect.
- R7: On a 16-bit bank (`cfg_bank16` bit = 1), a 16-bit request uses `io_bs_n` = 2'b00 and the full data word. A byte request uses `io_bs_n` = 2'b10 when address bit 0 is 0, or 2'b01 when it is 1. The byte `req_wdata[7:0]` is written on both data lanes. A byte read returns the selected lane in `rsp_rdata[7:0]` with the upper byte zero.
- R8: On an 8-bit bank, every cycle uses `io_bs_n` = 2'b10 and data lane [7:0]. A 16-bit request becomes two byte cycles. The first goes to address A with `req_wdata[7:0]`, the second to A+1 with `req_wdata[15:8]`. A read returns {second byte, first byte}. A byte read returns zero in the upper byte.
- R9: `req_ready` is 1 only when idle. Timing inputs are sampled at acceptance. `rsp_valid` is a one-cycle pulse, high N×(S+W+D+3) cycles after the accepting edge, where N is the number of byte or word cycles. `rsp_rdata` is zero for writes. A request held valid during the pulse is accepted at the end of that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | Target bank |
| req_wide | input | 1 | 1 = 16-bit request, 0 = byte request |
| req_addr | input | 22 | Byte address |
| req_wdata | input | 16 | Write data |
| cfg_bank16 | input | 2 | Per-bank width, 1 = 16-bit device |
| cfg_setup | input | 4 | Address setup, cycles minus one |
| cfg_rd_width | input | 4 | Read strobe width, cycles minus one |
| cfg_wr_width | input | 4 | Write strobe width, cycles minus one |
| cfg_data_off | input | 4 | Post-strobe hold / data-off, cycles minus one |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| io_cs_n | output | 2 | Active-low chip select per bank |
| io_addr | output | 22 | External address |
| io_bs_n | output | 2 | Active-low byte selects, bit 0 = lane [7:0] |
| io_re_n | output | 1 | Active-low read strobe |
| io_we_n | output | 1 | Active-low write strobe |
| io_data_o | output | 16 | Data driven to the bus |
| io_data_oe | output | 1 | Drive enable for io_data_o |
| io_data_i | input | 16 | Data from the bus |
| io_wait_n | input | 2 | Active-low wait per bank, asynchronous |

## Verification
Two events can coincide here: the completion pulse of one access and the acceptance of the next. The bench provokes this by holding `req_valid` high with a second request to the other bank while the first access runs. In the pulse cycle it checks that `req_ready` is already high and that the first access's read data is correct. One cycle later it checks that the new bank's chip select is low and its byte selects are correct. A second overlap is a wait release that lands near the end of the minimum strobe width. It is judged by counting strobe cycles against the synchroniser latency stated in R5 and R6.

// File: rtl/xio_pkg.sv
`timescale 1ns/1ps
package xio_pkg;
  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_SETUP  = 2'd1,
    XS_STROBE = 2'd2,
    XS_HOLD   = 2'd3
  } xio_state_e;
endpackage

// File: rtl/xio_wait_sync.sv
`timescale 1ns/1ps
// Two-stage synchroniser per bank for the asynchronous wait inputs.
module xio_wait_sync #(
  parameter int N_BANK = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_BANK-1:0] wait_n_i,
  output logic [N_BANK-1:0] wait_n_o
);
  genvar g;
  generate
    for (g = 0; g < N_BANK; g++) begin : g_bank
      logic s1, s2;
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          s1 <= 1'b1;
          s2 <= 1'b1;
        end else begin
          s1 <= wait_n_i[g];
          s2 <= s1;
        end
      end
      assign wait_n_o[g] = s2;
    end
  endgenerate
endmodule

// File: rtl/xio_lane_map.sv
`timescale 1ns/1ps
// Byte-lane steering for writes and lane selection for reads.
module xio_lane_map #(
  parameter int DW = 16
) (
  input  logic          bank16,
  input  logic          wide,
  input  logic          addr_lsb,
  input  logic          upper_half,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rd_bus,
  output logic [1:0]    bs_n,
  output logic [DW-1:0] data_o,
  output logic [DW/2-1:0] rd_byte
);
  localparam int BW = DW / 2;

  logic [BW-1:0] byte_sel;

  always_comb begin
    byte_sel = upper_half ? wdata[DW-1:BW] : wdata[BW-1:0];
    if (bank16 && wide) begin
      bs_n   = 2'b00;
      data_o = wdata;
    end else if (bank16) begin
      bs_n   = addr_lsb ? 2'b01 : 2'b10;
      data_o = {byte_sel, byte_sel};
    end else begin
      bs_n   = 2'b10;
      data_o = {byte_sel, byte_sel};
    end
    rd_byte = (bank16 && addr_lsb) ? rd_bus[DW-1:BW] : rd_bus[BW-1:0];
  end
endmodule

// File: rtl/xio_seq.sv
`timescale 1ns/1ps
// Access sequencer: setup, strobe (with wait stretch), hold, optional second byte.
module xio_seq
  import xio_pkg::*;
#(
  parameter int N_BANK = 2,
  parameter int BANK_W = 1,
  parameter int AW     = 22,
  parameter int DW     = 16,
  parameter int CW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              req_wide,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [N_BANK-1:0] cfg_bank16,
  input  logic [CW-1:0]     cfg_setup,
  input  logic [CW-1:0]     cfg_rd_width,
  input  logic [CW-1:0]     cfg_wr_width,
  input  logic [CW-1:0]     cfg_data_off,
  input  logic [N_BANK-1:0] wait_n_s,
  input  logic [DW-1:0]     rd_bus,
  input  logic [DW/2-1:0]   rd_byte,
  output logic              req_ready,
  output logic              busy,
  output logic              strobe_on,
  output logic              cur_write,
  output logic [BANK_W-1:0] cur_bank,
  output logic              cur_bank16,
  output logic              cur_wide,
  output logic              cur_half,
  output logic [AW-1:0]     cur_addr,
  output logic [DW-1:0]     cur_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata
);
  localparam int BW = DW / 2;

  xio_state_e        st;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     q_setup, q_strobe, q_doff;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st         <= XS_IDLE;
      cnt        <= '0;
      q_setup    <= '0;
      q_strobe   <= '0;
      q_doff     <= '0;
      cur_write  <= 1'b0;
      cur_bank   <= '0;
      cur_bank16 <= 1'b0;
      cur_wide   <= 1'b0;
      cur_half   <= 1'b0;
      cur_addr   <= '0;
      cur_wdata  <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        XS_IDLE: begin
          if (req_valid) begin
            cur_write  <= req_write;
            cur_bank   <= req_bank;
            cur_bank16 <= cfg_bank16[req_bank];
            cur_wide   <= req_wide;
            cur_half   <= 1'b0;
            cur_addr   <= req_addr;
            cur_wdata  <= req_wdata;
            q_setup    <= cfg_setup;
            q_strobe   <= req_write ? cfg_wr_width : cfg_rd_width;
            q_doff     <= cfg_data_off;
            cnt        <= cfg_setup;
            rsp_rdata  <= '0;
            st         <= XS_SETUP;
          end
        end
        XS_SETUP: begin
          if (cnt == '0) begin
            cnt <= q_strobe;
            st  <= XS_STROBE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        XS_STROBE: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (wait_n_s[cur_bank]) begin
            cnt <= q_doff;
            st  <= XS_HOLD;
            if (!cur_write) begin
              if (cur_bank16 && cur_wide) rsp_rdata <= rd_bus;
              else if (cur_half)          rsp_rdata[DW-1:BW] <= rd_byte;
              else                        rsp_rdata <= {{BW{1'b0}}, rd_byte};
            end
          end
        end
        XS_HOLD: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (cur_wide && !cur_bank16 && !cur_half) begin
            cur_half <= 1'b1;
            cur_addr <= cur_addr + 1'b1;
            cnt      <= q_setup;
            st       <= XS_SETUP;
          end else begin
            rsp_valid <= 1'b1;
            st        <= XS_IDLE;
          end
        end
        default: st <= XS_IDLE;
      endcase
    end
  end

  assign req_ready = (st == XS_IDLE);
  assign busy      = (st != XS_IDLE);
  assign strobe_on = (st == XS_STROBE);

  // The completion pulse lasts exactly one cycle.
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);                                         // R9
  // The second byte cycle always goes one address above the first.
  AST_HALF_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    $rose(cur_half) |-> cur_addr == $past(cur_addr) + 1'b1);           // R8
endmodule

// File: rtl/xio_bus_ctrl.sv
`timescale 1ns/1ps
// Top: external peripheral bus sequencer for two banks.
module xio_bus_ctrl #(
  parameter int  N_BANK = 2,
  parameter int  AW     = 22,
  parameter int  DW     = 16,
  parameter int  CW     = 4,
  localparam int BANK_W = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              req_wide,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [N_BANK-1:0] cfg_bank16,
  input  logic [CW-1:0]     cfg_setup,
  input  logic [CW-1:0]     cfg_rd_width,
  input  logic [CW-1:0]     cfg_wr_width,
  input  logic [CW-1:0]     cfg_data_off,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [N_BANK-1:0] io_cs_n,
  output logic [AW-1:0]     io_addr,
  output logic [1:0]        io_bs_n,
  output logic              io_re_n,
  output logic              io_we_n,
  output logic [DW-1:0]     io_data_o,
  output logic              io_data_oe,
  input  logic [DW-1:0]     io_data_i,
  input  logic [N_BANK-1:0] io_wait_n
);
  logic [N_BANK-1:0] wait_n_s;
  logic              busy, strobe_on, cur_write, cur_bank16, cur_wide, cur_half;
  logic [BANK_W-1:0] cur_bank;
  logic [AW-1:0]     cur_addr;
  logic [DW-1:0]     cur_wdata;
  logic [DW/2-1:0]   rd_byte;
  logic [1:0]        lane_bs_n;

  xio_wait_sync #(.N_BANK(N_BANK)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .wait_n_i (io_wait_n),
    .wait_n_o (wait_n_s)
  );

  xio_seq #(
    .N_BANK(N_BANK), .BANK_W(BANK_W), .AW(AW), .DW(DW), .CW(CW)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_bank     (req_bank),
    .req_wide     (req_wide),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .cfg_bank16   (cfg_bank16),
    .cfg_setup    (cfg_setup),
    .cfg_rd_width (cfg_rd_width),
    .cfg_wr_width (cfg_wr_width),
    .cfg_data_off (cfg_data_off),
    .wait_n_s     (wait_n_s),
    .rd_bus       (io_data_i),
    .rd_byte      (rd_byte),
    .req_ready    (req_ready),
    .busy         (busy),
    .strobe_on    (strobe_on),
    .cur_write    (cur_write),
    .cur_bank     (cur_bank),
    .cur_bank16   (cur_bank16),
    .cur_wide     (cur_wide),
    .cur_half     (cur_half),
    .cur_addr     (cur_addr),
    .cur_wdata    (cur_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata)
  );

  xio_lane_map #(.DW(DW)) u_lanes (
    .bank16     (cur_bank16),
    .wide       (cur_wide),
    .addr_lsb   (cur_addr[0]),
    .upper_half (cur_half),
    .wdata      (cur_wdata),
    .rd_bus     (io_data_i),
    .bs_n       (lane_bs_n),
    .data_o     (io_data_o),
    .rd_byte    (rd_byte)
  );

  genvar g;
  generate
    for (g = 0; g < N_BANK; g++) begin : g_cs
      assign io_cs_n[g] = !(busy && (cur_bank == BANK_W'(g)));
    end
  endgenerate

  assign io_addr    = cur_addr;
  assign io_bs_n    = busy ? lane_bs_n : 2'b11;
  assign io_re_n    = !(strobe_on && !cur_write);
  assign io_we_n    = !(strobe_on && cur_write);
  assign io_data_oe = busy && cur_write;

  AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~io_cs_n));                                               // R1
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(!io_re_n && !io_we_n));                                          // R3
  AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    (!io_re_n || !io_we_n) |-> !(&io_cs_n));                           // R2
  AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    ($rose(io_re_n) || $rose(io_we_n)) |-> (!(&io_cs_n) && $stable(io_addr))); // R4
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
    ((!io_re_n || !io_we_n) && $past(!io_re_n || !io_we_n))
      |-> ($stable(io_addr) && $stable(io_bs_n)));                     // R3
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    !io_we_n |-> io_data_oe);                                          // R4
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (&io_cs_n && io_re_n && io_we_n));                   // R9
endmodule

// File: tb/xio_bus_ctrl_bench.sv
`timescale 1ns/1ps
module xio_bus_ctrl_bench;
  localparam int AW = 22, DW = 16, CW = 4, NB = 2;

  typedef struct packed {
    logic          wr;
    logic          bank;
    logic          wide;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [3:0]    s;
    logic [3:0]    w;
    logic [3:0]    d;
  } vec_t;

  // bank 0 is 16-bit, bank 1 is 8-bit
  localparam vec_t VECS [0:8] = '{
    '{1'b1, 1'b0, 1'b1, 22'h001234, 16'hBEEF, 4'd1, 4'd2, 4'd0},
    '{1'b0, 1'b0, 1'b1, 22'h000040, 16'h0000, 4'd0, 4'd0, 4'd1},
    '{1'b1, 1'b0, 1'b0, 22'h000101, 16'h00A7, 4'd2, 4'd1, 4'd2},
    '{1'b0, 1'b0, 1'b0, 22'h000103, 16'h0000, 4'd0, 4'd3, 4'd0},
    '{1'b0, 1'b0, 1'b0, 22'h000222, 16'h0000, 4'd1, 4'd1, 4'd0},
    '{1'b1, 1'b1, 1'b1, 22'h3FFF10, 16'h5AC3, 4'd1, 4'd0, 4'd1},
    '{1'b0, 1'b1, 1'b1, 22'h000017, 16'h0000, 4'd3, 4'd2, 4'd0},
    '{1'b0, 1'b1, 1'b0, 22'h0000F0, 16'h0000, 4'd0, 4'd0, 4'd0},
    '{1'b1, 1'b1, 1'b0, 22'h2AAAAA, 16'h1234, 4'd0, 4'd1, 4'd3}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic          req_valid, req_ready, req_write, req_wide;
  logic [0:0]    req_bank;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [NB-1:0] cfg_bank16;
  logic [CW-1:0] cfg_setup, cfg_rd_width, cfg_wr_width, cfg_data_off;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [NB-1:0] io_cs_n;
  logic [AW-1:0] io_addr;
  logic [1:0]    io_bs_n;
  logic          io_re_n, io_we_n, io_data_oe;
  logic [DW-1:0] io_data_o, io_data_i;
  logic [NB-1:0] io_wait_n;

  function automatic logic [7:0] dev_lo(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] dev_hi(input logic [AW-1:0] a);
    return a[7:0] + 8'h11;
  endfunction

  assign io_data_i = {dev_hi(io_addr), dev_lo(io_addr)};

  xio_bus_ctrl u_xio_bus_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_bank16(cfg_bank16), .cfg_setup(cfg_setup), .cfg_rd_width(cfg_rd_width),
    .cfg_wr_width(cfg_wr_width), .cfg_data_off(cfg_data_off),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .io_cs_n(io_cs_n), .io_addr(io_addr), .io_bs_n(io_bs_n),
    .io_re_n(io_re_n), .io_we_n(io_we_n), .io_data_o(io_data_o),
    .io_data_oe(io_data_oe), .io_data_i(io_data_i), .io_wait_n(io_wait_n)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic drive_req(input vec_t v);
    req_write    = v.wr;
    req_bank     = v.bank;
    req_wide     = v.wide;
    req_addr     = v.addr;
    req_wdata    = v.wdata;
    cfg_setup    = v.s;
    cfg_rd_width = v.wr ? v.w + 4'd5 : v.w;
    cfg_wr_width = v.wr ? v.w : v.w + 4'd5;
    cfg_data_off = v.d;
    req_valid    = 1'b1;
  endtask

  task automatic run_vec(input vec_t v);
    int k = 0, ph = 0, setup_n = 0, hold_n = 0;
    int slen [0:3] = '{default: 0};
    logic [AW-1:0] sa [0:3] = '{default: '0};
    logic [1:0]    sb [0:3] = '{default: '0};
    logic [DW-1:0] sd [0:3] = '{default: '0};
    bit in_str = 0, oe_bad = 0, cs_bad = 0, done = 0;
    logic [NB-1:0] exp_cs;
    logic [DW-1:0] got_rd, exp_rd, exp_wd;
    logic [1:0]    exp_bs;
    logic          b16;
    int phases, lat;
    string lane_tag;
    @(negedge clk);
    drive_req(v);
    @(posedge clk);
    exp_cs = v.bank ? 2'b01 : 2'b10;
    got_rd = '0;
    while (!done && k < 400) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
        cfg_setup = 4'hF; cfg_rd_width = 4'hF; cfg_wr_width = 4'hF; cfg_data_off = 4'hF;
      end
      if (rsp_valid) begin
        done   = 1;
        got_rd = rsp_rdata;
      end else begin
        if (!io_re_n || !io_we_n) begin
          if (!in_str) begin
            in_str = 1;
            if (ph < 3) ph++;
          end
          slen[ph]++;
          sa[ph] = io_addr;
          sb[ph] = io_bs_n;
          sd[ph] = io_data_o;
          hold_n = 0;
        end else begin
          in_str = 0;
          if (io_cs_n != 2'b11) begin
            if (ph == 0) setup_n++;
            else hold_n++;
          end
        end
        if (io_cs_n != 2'b11) begin
          if (io_cs_n != exp_cs) cs_bad = 1;
          if (io_data_oe !== v.wr) oe_bad = 1;
        end
        @(posedge clk);
        k++;
      end
    end
    b16      = !v.bank;
    phases   = (v.wide && !b16) ? 2 : 1;
    lat      = phases * (int'(v.s) + int'(v.w) + int'(v.d) + 3);
    lane_tag = b16 ? "R7 lanes" : "R8 lanes";
    check("R9 latency", k, lat);
    check("R2 setup cycles", setup_n, v.s + 1);
    check("R3 strobe width", slen[1], v.w + 1);
    check("R4 hold cycles", hold_n, v.d + 1);
    check("R1 chip select", cs_bad, 0);
    check("R4 drive enable", oe_bad, 0);
    check("R8 cycle count", ph, phases);
    check("R3 address", sa[1], v.addr);
    exp_bs = (b16 && v.wide) ? 2'b00 : (b16 ? (v.addr[0] ? 2'b01 : 2'b10) : 2'b10);
    check(lane_tag, sb[1], exp_bs);
    if (phases == 2) begin
      check("R8 second address", sa[2], v.addr + 1'b1);
      check("R8 second byte select", sb[2], 2'b10);
      if (v.wr) check("R8 second write byte", sd[2], {v.wdata[15:8], v.wdata[15:8]});
    end
    if (v.wr) begin
      exp_wd = (b16 && v.wide) ? v.wdata : {v.wdata[7:0], v.wdata[7:0]};
      check(lane_tag, sd[1], exp_wd);
      check("R9 write response data", got_rd, 16'h0000);
    end else begin
      if (b16 && v.wide)  exp_rd = {dev_hi(v.addr), dev_lo(v.addr)};
      else if (b16)       exp_rd = {8'h00, v.addr[0] ? dev_hi(v.addr) : dev_lo(v.addr)};
      else if (v.wide)    exp_rd = {dev_lo(v.addr + 1'b1), dev_lo(v.addr)};
      else                exp_rd = {8'h00, dev_lo(v.addr)};
      check(lane_tag, got_rd, exp_rd);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ok;
    int n;
    vec_t dv;
    rst = 1'b1;
    req_valid = 1'b0; req_write = 1'b0; req_bank = 1'b0; req_wide = 1'b0;
    req_addr = '0; req_wdata = '0;
    cfg_bank16 = 2'b01;
    cfg_setup = '0; cfg_rd_width = '0; cfg_wr_width = '0; cfg_data_off = '0;
    io_wait_n = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset / idle state
    check("R1 idle cs", io_cs_n, 2'b11);
    check("R1 idle bs", io_bs_n, 2'b11);
    check("R1 idle strobes", {io_re_n, io_we_n}, 2'b11);
    check("R1 idle drive", io_data_oe, 1'b0);
    check("R9 idle ready", req_ready, 1'b1);
    check("R9 idle response", rsp_valid, 1'b0);

    // table walk
    for (int i = 0; i <= 8; i++) run_vec(VECS[i]);

    // R6: wait of the non-selected bank has no effect
    @(negedge clk);
    io_wait_n = 2'b01;
    repeat (3) @(negedge clk);
    run_vec('{1'b0, 1'b0, 1'b1, 22'h000333, 16'h0000, 4'd0, 4'd2, 4'd0});
    @(negedge clk);
    io_wait_n = 2'b11;
    repeat (3) @(negedge clk);

    // R5: wait stretches the strobe; rises on the third edge after release
    io_wait_n = 2'b10;
    repeat (3) @(negedge clk);
    dv = '{1'b0, 1'b0, 1'b1, 22'h000080, 16'h0000, 4'd0, 4'd1, 4'd0};
    drive_req(dv);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (io_re_n && n < 50) begin
      @(negedge clk);
      n++;
    end
    repeat (6) @(negedge clk);
    check("R5 strobe held", io_re_n, 1'b0);
    io_wait_n = 2'b11;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!io_re_n && n < 20);
    check("R5 release latency", n, 3);
    wait_done(ok);
    check("R5 done after stretch", ok, 1'b1);
    check("R5 read data", rsp_rdata, {dev_hi(22'h000080), dev_lo(22'h000080)});

    // R6: short wait pulse inside the minimum width is ignored
    @(negedge clk);
    dv = '{1'b0, 1'b0, 1'b1, 22'h0000C0, 16'h0000, 4'd0, 4'd5, 4'd0};
    drive_req(dv);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (io_re_n && n < 50) @(negedge clk);
    n = 1;
    io_wait_n = 2'b10;
    @(negedge clk);
    if (!io_re_n) n++;
    @(negedge clk);
    if (!io_re_n) n++;
    io_wait_n = 2'b11;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (io_re_n) break;
      n++;
    end
    check("R6 early wait ignored", n, 6);
    wait_done(ok);
    check("R6 done", ok, 1'b1);

    // R9: completion and next acceptance in the same cycle
    @(negedge clk);
    dv = '{1'b0, 1'b0, 1'b1, 22'h000055, 16'h0000, 4'd0, 4'd0, 4'd0};
    drive_req(dv);
    @(posedge clk);
    @(negedge clk);
    req_write = 1'b1; req_bank = 1'b1; req_wide = 1'b0;
    req_addr = 22'h000077; req_wdata = 16'h00C4;
    cfg_wr_width = 4'd0;
    check("R9 busy not ready", req_ready, 1'b0);
    ok = 1'b0;
    for (int i = 0; i < 50; i++) begin
      if (rsp_valid) begin
        ok = 1'b1;
        break;
      end
      @(negedge clk);
    end
    check("R9 first done", ok, 1'b1);
    check("R9 ready with done", req_ready, 1'b1);
    check("R9 first read data", rsp_rdata, {dev_hi(22'h000055), dev_lo(22'h000055)});
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 next bank selected", io_cs_n, 2'b01);
    check("R8 next byte select", io_bs_n, 2'b10);
    wait_done(ok);
    check("R9 second done", ok, 1'b1);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule